// File: doc/BRIEF.md
# Two-Wire Configuration Receiver with Frame-Synchronous Register Commit

This block lets a host processor configure a video encoder over a two-wire I2C bus. It acts as a write-only bus target. It answers to one of two 7-bit device addresses, and a strap pin picks which one. The first byte after the device address selects a register index. Each following data byte lands in a shadow register bank, and the index advances by one after every byte. Both SCL and SDA are brought into the system clock domain through a two-flop synchronizer. All bus events are found by sampling those synchronized lines.

Settings written by the host do not reach the encoder straight away. The active register bank, which is what drives the encoder, copies the whole shadow bank in one cycle. This copy happens only on a falling edge of vertical sync, and only while a write-enable bit in a control register is set. That bit then clears itself, so a frame never starts with a half-updated configuration. The host writes a batch of registers, sets the write-enable bit last, and the batch takes effect at the next vertical sync fall.

Top module: `vid_cfg_i2c_slave`

## Requirements
- R1: The block acknowledges, by driving `sda_oe` high during the ninth SCL clock, a write request to 7-bit address `DEV_BASE` (default 20h, first byte 40h) when `addr_sel` is 0, and to `DEV_BASE|1` (first byte 42h) when `addr_sel` is 1.
- R2: A first byte with a non-matching address, or with bit 0 (the read/write bit) equal to 1, gets no acknowledge. The rest of that transaction writes nothing.
- R3: The byte after an acknowledged address is a register index. Its low log2(NUM_REGS) bits select the shadow register, and it is acknowledged.
- R4: Each data byte is acknowledged and stored in the shadow register at the current index. The index then increments modulo NUM_REGS.
- R5: The active outputs change only on a falling edge of the synchronized `vsync_i` while the write-enable bit is set. A rising edge does nothing. On that falling edge the active outputs take every shadow register at once.
- R6: The write-enable bit is bit 0 of register NUM_REGS-1. After a commit it reads 0 both in the shadow bank and in the active copy. A later vsync fall with no new write therefore changes nothing.
- R7: A vsync fall with the write-enable bit clear leaves the active outputs unchanged, even when the shadow bank holds new data.
- R8: A STOP condition (SDA rising while SCL is high) or a START condition (SDA falling while SCL is high) restarts the byte receiver at any point. A partly received byte is dropped, and the byte after a repeated START is again a device address.
- R9: Standard-mode (100 kHz) and fast-mode (400 kHz) SCL timing are both received correctly.
- R10: After reset all shadow and active registers are 0 and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain acknowledge) |
| addr_sel | input | 1 | Picks the device address: 0 gives DEV_BASE, 1 gives DEV_BASE\|1 |
| vsync_i | input | 1 | Vertical sync from the video timing |
| act_regs_o | output | NUM_REGS*8 | Active registers, register i at bits [8i+7:8i] |

## Verification
The bench builds the block with NUM_REGS = 8. A burst of three bytes starting at index 6 therefore wraps the index back to 0, and the control register sits at index 7. At this size a register index byte of 0Eh reaches the same register as 06h, which exercises the dropping of the upper index bits. DEV_BASE stays at 20h, so 40h and 42h select the two pin-chosen addresses. One transaction is run with standard-mode SCL and the rest with fast-mode SCL.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  typedef enum logic [1:0] {
    BS_IDLE,
    BS_RECV,
    BS_ACK,
    BS_SKIP
  } bstate_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_SUB,
    PH_DATA
  } bphase_t;

  // First bus byte: 7-bit address in [7:1], read flag in [0].
  function automatic logic match_dev(input logic [7:0] b,
                                     input logic [6:0] base,
                                     input logic       sel);
    return (b[7:1] == (base | {6'd0, sel})) && !b[0];
  endfunction

  function automatic bphase_t next_phase(input bphase_t ph);
    return (ph == PH_ADDR) ? PH_SUB : PH_DATA;
  endfunction

  function automatic logic [7:0] strip_bit(input logic [7:0] v, input int pos);
    return v & ~(8'd1 << pos);
  endfunction

endpackage

// File: rtl/vcfg_sync_chain.sv
module vcfg_sync_chain #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/vcfg_i2c_rx.sv
module vcfg_i2c_rx #(
  parameter int         NUM_REGS = 16,
  parameter logic [6:0] DEV_BASE = 7'h20,
  localparam int        IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             addr_sel,
  output logic             sda_oe,
  output logic             start_evt,
  output logic             stop_evt,
  output logic             byte_done,
  output logic             addr_hit,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  import vcfg_pkg::*;

  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  bstate_t          state;
  bphase_t          phase;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [IDX_W-1:0] ptr;
  logic             scl_d, sda_d;
  logic             scl_rise, scl_fall, accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

  assign byte_done = (state == BS_RECV) && (bit_cnt == 4'd8) && scl_fall;
  assign addr_hit  = byte_done && (phase == PH_ADDR) &&
                     match_dev(shreg, DEV_BASE, addr_sel);
  assign accept    = byte_done && ((phase != PH_ADDR) || addr_hit);
  assign wr_en     = byte_done && (phase == PH_DATA);
  assign wr_idx    = ptr;
  assign wr_data   = shreg;
  assign sda_oe    = (state == BS_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= BS_IDLE;
      phase   <= PH_ADDR;
      bit_cnt <= 4'd0;
      shreg   <= 8'd0;
      ptr     <= '0;
    end else if (start_evt) begin
      state   <= BS_RECV;
      phase   <= PH_ADDR;
      bit_cnt <= 4'd0;
    end else if (stop_evt) begin
      state   <= BS_IDLE;
      phase   <= PH_ADDR;
      bit_cnt <= 4'd0;
    end else begin
      unique case (state)
        BS_RECV: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            if (accept) begin
              state <= BS_ACK;
              if (phase == PH_SUB)  ptr <= shreg[IDX_W-1:0];
              if (phase == PH_DATA) ptr <= ptr + IDX_ONE;
            end else begin
              state <= BS_SKIP;
            end
          end
        end
        BS_ACK: begin
          if (scl_fall) begin
            state   <= BS_RECV;
            bit_cnt <= 4'd0;
            phase   <= next_phase(phase);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vcfg_reg_bank.sv
module vcfg_reg_bank #(
  parameter int  NUM_REGS = 16,
  parameter int  WE_BIT   = 0,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int CTRL_IDX = NUM_REGS - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic                  commit,
  output logic                  we_flag,
  output logic [NUM_REGS*8-1:0] act_flat
);
  import vcfg_pkg::*;

  logic [7:0] shadow_q [NUM_REGS];
  logic [7:0] active_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    localparam bit               IS_CTRL = (i == CTRL_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[i] <= 8'd0;
      end else if (wr_en && wr_idx == MY_IDX) begin
        shadow_q[i] <= wr_data;
      end else if (commit && IS_CTRL) begin
        shadow_q[i] <= strip_bit(shadow_q[i], WE_BIT);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active_q[i] <= 8'd0;
      end else if (commit) begin
        active_q[i] <= IS_CTRL ? strip_bit(shadow_q[i], WE_BIT) : shadow_q[i];
      end
    end

    assign act_flat[i*8 +: 8] = active_q[i];
  end

  assign we_flag = shadow_q[CTRL_IDX][WE_BIT];
endmodule

// File: rtl/vcfg_vsync_commit.sv
module vcfg_vsync_commit (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_s,
  input  logic we_flag,
  output logic commit
);
  logic vs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_d <= 1'b0;
    else        vs_d <= vs_s;
  end

  assign commit = vs_d & ~vs_s & we_flag;
endmodule

// File: rtl/vid_cfg_i2c_slave.sv
module vid_cfg_i2c_slave #(
  parameter int         NUM_REGS    = 16,
  parameter logic [6:0] DEV_BASE    = 7'h20,
  parameter int         WE_BIT      = 0,
  parameter int         SYNC_STAGES = 2,
  localparam int        IDX_W       = $clog2(NUM_REGS),
  localparam int        ACT_W       = NUM_REGS * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             addr_sel,
  input  logic             vsync_i,
  output logic [ACT_W-1:0] act_regs_o
);
  logic             scl_s, sda_s, vs_s;
  logic             start_evt, stop_evt, byte_done, addr_hit;
  logic             wr_en, we_flag, commit_evt;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  vcfg_sync_chain #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  vcfg_sync_chain #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_vs_sync (
    .clk(clk), .rst_n(rst_n), .d(vsync_i), .q(vs_s)
  );

  vcfg_i2c_rx #(.NUM_REGS(NUM_REGS), .DEV_BASE(DEV_BASE)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .start_evt(start_evt),
    .stop_evt(stop_evt), .byte_done(byte_done), .addr_hit(addr_hit),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  vcfg_reg_bank #(.NUM_REGS(NUM_REGS), .WE_BIT(WE_BIT)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .commit(commit_evt), .we_flag(we_flag),
    .act_flat(act_regs_o)
  );

  vcfg_vsync_commit u_commit (
    .clk(clk), .rst_n(rst_n), .vs_s(vs_s), .we_flag(we_flag),
    .commit(commit_evt)
  );
endmodule

// File: rtl/vid_cfg_i2c_checker.sv
module vid_cfg_i2c_checker #(
  parameter int NUM_REGS = 16,
  parameter int WE_BIT   = 0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sda_oe,
  input logic                  start_evt,
  input logic                  stop_evt,
  input logic                  byte_done,
  input logic                  addr_hit,
  input logic                  wr_en,
  input logic                  commit_evt,
  input logic [NUM_REGS*8-1:0] act_regs_o
);
  localparam int WE_POS = (NUM_REGS - 1) * 8 + WE_BIT;

  p_ack_follows_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(byte_done));

  p_addr_acked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> sda_oe);

  p_data_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);

  p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(act_regs_o));

  p_we_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> !act_regs_o[WE_POS]);

  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  p_start_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);
endmodule

bind vid_cfg_i2c_slave vid_cfg_i2c_checker #(.NUM_REGS(NUM_REGS), .WE_BIT(WE_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .start_evt(start_evt),
  .stop_evt(stop_evt), .byte_done(byte_done), .addr_hit(addr_hit),
  .wr_en(wr_en), .commit_evt(commit_evt), .act_regs_o(act_regs_o)
);

// File: tb/vid_cfg_i2c_slave_test.sv
module vid_cfg_i2c_slave_test;
  localparam int NR      = 8;
  localparam int HP_FAST = 1260;
  localparam int HP_STD  = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0, vsync = 1'b0;
  logic sda_oe;
  logic [NR*8-1:0] act;
  wire sda_line = sda_m & ~sda_oe;

  int hp = HP_FAST;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [7:0] sm [NR];
  logic [7:0] am [NR];

  vid_cfg_i2c_slave #(.NUM_REGS(NR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .addr_sel(addr_sel), .vsync_i(vsync), .act_regs_o(act)
  );

  typedef struct packed {
    logic        sel;
    logic [7:0]  dev;
    logic [7:0]  sub;
    logic [2:0]  n;
    logic [31:0] data;
    logic        fast;
    logic        vs;
    logic        ack;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b0, 8'h40, 8'h00, 3'd3, 32'h00332211, 1'b1, 1'b1, 1'b1},
    '{1'b0, 8'h40, 8'h06, 3'd2, 32'h000001A6, 1'b0, 1'b1, 1'b1},
    '{1'b0, 8'h42, 8'h03, 3'd1, 32'h00000077, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'h42, 8'h0E, 3'd3, 32'h0099815C, 1'b1, 1'b1, 1'b1},
    '{1'b1, 8'h43, 8'h01, 3'd1, 32'h000000EE, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'h40, 8'h01, 3'd1, 32'h000000DD, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h40, 8'h07, 3'd1, 32'h00000000, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [NR*8-1:0] model_flat();
    logic [NR*8-1:0] f;
    for (int i = 0; i < NR; i++) f[i*8 +: 8] = am[i];
    return f;
  endfunction

  task automatic vs_model();
    if (sm[NR-1][0]) begin
      sm[NR-1][0] = 1'b0;
      for (int i = 0; i < NR; i++) am[i] = sm[i];
    end
  endtask

  task automatic pulse_vs();
    vsync = 1'b1; #400;
    vsync = 1'b0; #400;
    vs_model();
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; #(hp);
    scl_m = 1'b1; #(hp);
    sda_m = 1'b0; #(hp);
    scl_m = 1'b0; #(hp);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; #(hp);
    scl_m = 1'b1; #(hp);
    sda_m = 1'b1; #(hp);
  endtask

  task automatic i2c_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; #(hp);
      scl_m = 1'b1; #(hp);
      scl_m = 1'b0;
    end
  endtask

  task automatic i2c_byte(input logic [7:0] b, output logic ack);
    i2c_bits(b, 8);
    sda_m = 1'b1; #(hp);
    scl_m = 1'b1; #(hp/2);
    ack = ~sda_line;
    #(hp/2);
    scl_m = 1'b0; #(hp);
  endtask

  task automatic wr_body(input logic [7:0] sub, input int n,
                         input logic [31:0] data, input bit model_on,
                         output bit all_ok);
    logic a;
    logic [2:0] p;
    p = sub[2:0];
    i2c_byte(sub, a);
    all_ok = a;
    for (int k = 0; k < n; k++) begin
      i2c_byte(data[8*k +: 8], a);
      all_ok &= a;
      if (model_on) sm[p] = data[8*k +: 8];
      p = p + 3'd1;
    end
  endtask

  task automatic wr_txn(input logic [7:0] dev, input logic [7:0] sub,
                        input int n, input logic [31:0] data,
                        input bit exp_ack, input string tag);
    logic a;
    bit ok;
    i2c_start();
    i2c_byte(dev, a);
    check(a == exp_ack, {tag, " address ack"}, 64'(a), 64'(exp_ack));
    if (exp_ack) begin
      wr_body(sub, n, data, 1'b1, ok);
      check(ok, {tag, " R3 R4 index and data acks"}, 64'(ok), 64'd1);
    end
    i2c_stop();
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin sm[i] = 8'd0; am[i] = 8'd0; end
    #105;
    check(act == '0, "R10 active during reset", act, 64'd0);
    rst_n = 1'b1;
    #40;
    check(act == '0 && sda_oe == 1'b0, "R10 reset state", {act[62:0], sda_oe}, 64'd0);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < 7; v++) begin
      addr_sel = VEC[v].sel;
      hp = VEC[v].fast ? HP_FAST : HP_STD;
      #200;
      wr_txn(VEC[v].dev, VEC[v].sub, int'(VEC[v].n), VEC[v].data, VEC[v].ack,
             $sformatf("R1 R2 R9 vec%0d", v));
      if (VEC[v].vs) pulse_vs();
      #200;
      check(act == model_flat(), $sformatf("R5 R6 R7 active after vec%0d", v),
            act, model_flat());
    end
    hp = HP_FAST;
    addr_sel = 1'b0;

    // R8: STOP inside a data byte drops the partial byte
    begin
      logic a;
      bit ok;
      i2c_start();
      i2c_byte(8'h40, a);
      i2c_byte(8'h01, a);
      i2c_bits(8'hF0, 4);
      i2c_stop();
      wr_txn(8'h40, 8'h07, 1, 32'h1, 1'b1, "R8 after stop");
      pulse_vs();
      #200;
      check(act == model_flat(), "R8 partial byte discarded", act, model_flat());

      // R8: repeated START restarts with a device address
      i2c_start();
      i2c_byte(8'h40, a);
      wr_body(8'h02, 1, 32'h5A, 1'b1, ok);
      i2c_start();
      i2c_byte(8'h40, a);
      check(a == 1'b1, "R8 address after repeated start acked", 64'(a), 64'd1);
      wr_body(8'h07, 1, 32'h1, 1'b1, ok);
      check(ok, "R8 bytes after repeated start acked", 64'(ok), 64'd1);
      i2c_stop();
      pulse_vs();
      #200;
      check(act == model_flat(), "R8 repeated start commit", act, model_flat());
    end

    // R5: only the falling edge of vsync commits
    wr_txn(8'h40, 8'h03, 1, 32'hC3, 1'b1, "R5 stage");
    wr_txn(8'h40, 8'h07, 1, 32'h1, 1'b1, "R5 arm");
    vsync = 1'b1; #400;
    check(act == model_flat(), "R5 rising edge no commit", act, model_flat());
    vsync = 1'b0; #400;
    vs_model();
    check(act == model_flat(), "R5 falling edge commit", act, model_flat());
    check(act[NR*8-8] == 1'b0, "R6 write-enable cleared in active copy",
          64'(act[NR*8-8]), 64'd0);
    pulse_vs();
    #200;
    check(act == model_flat() && sda_oe == 1'b0, "R6 second vsync no change",
          act, model_flat());

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule